// File: doc/BRIEF.md
# Two-Source Byte Permute Unit

This block builds a 128-bit result in which each of the 16 byte lanes is picked on its own from a 32-byte pool. The pool is two 128-bit source operands placed side by side. A third 128-bit operand supplies one control byte per output lane. Lanes choose freely, so one source byte may feed many lanes and any ordering is allowed. The block therefore works as a full 32-to-16 byte crossbar.

The same hardware serves two common uses. It can reorganise data: reverse bytes, interleave, splat or gather. It can also act as a parallel table lookup. In that use the two sources hold a 32-entry byte table and the control operand carries 16 indices, which are resolved in a single operation.

The operands are never written back. A request is accepted in any cycle where the valid input is high. The result appears in a register one clock later, together with its own valid flag.

Top module: `byte_permute_unit`

## Requirements
- R1: Byte lane k of a vector occupies bits [127-8k : 120-8k], so lane 0 is the most significant byte. Output lane k equals pool entry p. Here p is bits [4:0] of control lane k. Values 0..15 select lane p of `src_a`, and values 16..31 select lane p-16 of `src_b`.
- R2: Bits [7:5] of every control byte have no effect on the result.
- R3: Inputs sampled at a clock edge with `in_valid` high produce `result` and a high `out_valid` right after that same edge, which gives a latency of one cycle.
- R4: Requests on consecutive cycles each produce their own result on consecutive cycles. No cycle is lost between them.
- R5: After an edge where `in_valid` was low, `out_valid` is low and `result` keeps its previous value, whatever the operands were doing.
- R6: Reset is synchronous and active low. After an edge with `rst_n` low, `out_valid` is 0 and `result` is all zeros.
- R7: Each lane decodes independently of the others. Several lanes, or all 16, may select the same pool byte.
- R8: When the sources hold a 32-entry byte table, any set of 16 indices returns the 16 table entries in lane order.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| in_valid | input | 1 | Operands are valid this cycle |
| src_a | input | 128 | First source, pool entries 0..15 |
| src_b | input | 128 | Second source, pool entries 16..31 |
| ctrl | input | 128 | Per-lane selection bytes |
| out_valid | output | 1 | Result register holds a fresh result |
| result | output | 128 | Registered permuted vector |

## Verification
The checker assumes one thing about the inputs: `in_valid` and the three operands are stable around each rising edge. Apart from that, it accepts any operand values, including control bytes with their top three bits set. The bench meets this assumption by changing every input only on the falling clock edge. It drives the full range of control encodings: low indices, high indices, duplicated indices and dirty upper bits. Valid pulses are both isolated and back to back, so the latency and hold properties are exercised under both patterns.

// File: rtl/perm_pkg.sv
// Package: shared defaults and types for the byte permute unit.
// Assumes byte lane 0 is the most significant byte of a vector.
package perm_pkg;
    localparam int DEF_LANES  = 16;
    localparam int DEF_BYTE_W = 8;

    // Which half of the 32-byte pool a lane index points into.
    typedef enum logic {
        SRC_FIRST  = 1'b0,
        SRC_SECOND = 1'b1
    } src_sel_e;
endpackage

// File: rtl/perm_unpack.sv
// Module: perm_unpack
// Splits a flat vector into byte lanes, lane 0 taken from the top bits.
// Assumes VEC_W == LANES*BYTE_W; purely combinational.
module perm_unpack #(
    parameter int LANES  = perm_pkg::DEF_LANES,
    parameter int BYTE_W = perm_pkg::DEF_BYTE_W,
    localparam int VEC_W = LANES * BYTE_W
) (
    input  logic [VEC_W-1:0]              vec,
    output logic [LANES-1:0][BYTE_W-1:0]  lanes
);
    for (genvar k = 0; k < LANES; k++) begin : g_lane
        // Map lane k onto its slice counted from the most significant end.
        assign lanes[k] = vec[VEC_W-1-k*BYTE_W -: BYTE_W];
    end
endmodule

// File: rtl/perm_pack.sv
// Module: perm_pack
// Joins byte lanes back into a flat vector, lane 0 at the top bits.
// Assumes the same lane ordering as perm_unpack; purely combinational.
module perm_pack #(
    parameter int LANES  = perm_pkg::DEF_LANES,
    parameter int BYTE_W = perm_pkg::DEF_BYTE_W,
    localparam int VEC_W = LANES * BYTE_W
) (
    input  logic [LANES-1:0][BYTE_W-1:0]  lanes,
    output logic [VEC_W-1:0]              vec
);
    for (genvar k = 0; k < LANES; k++) begin : g_lane
        // Place lane k into its slice counted from the most significant end.
        assign vec[VEC_W-1-k*BYTE_W -: BYTE_W] = lanes[k];
    end
endmodule

// File: rtl/perm_lane_select.sv
// Module: perm_lane_select
// Chooses one byte from the 2*LANES pool for a single output lane.
// The index top bit picks the source, and the low bits pick the lane in it.
// Assumes LANES is a power of two; purely combinational.
module perm_lane_select #(
    parameter int LANES  = perm_pkg::DEF_LANES,
    parameter int BYTE_W = perm_pkg::DEF_BYTE_W,
    localparam int OFS_W = $clog2(LANES),
    localparam int IDX_W = OFS_W + 1
) (
    input  logic [LANES-1:0][BYTE_W-1:0]  pool_a,
    input  logic [LANES-1:0][BYTE_W-1:0]  pool_b,
    input  logic [IDX_W-1:0]              index,
    output logic [BYTE_W-1:0]             pick
);
    import perm_pkg::*;

    src_sel_e           half;
    logic [OFS_W-1:0]   offset;
    logic [BYTE_W-1:0]  pick_a;
    logic [BYTE_W-1:0]  pick_b;

    // Split the index into a source choice and a lane offset.
    always_comb begin
        half   = src_sel_e'(index[OFS_W]);
        offset = index[OFS_W-1:0];
    end

    // Select the addressed lane within each source independently.
    always_comb begin
        pick_a = pool_a[offset];
        pick_b = pool_b[offset];
    end

    // Final two-way choice between the sources.
    always_comb begin
        pick = (half == SRC_SECOND) ? pick_b : pick_a;
    end
endmodule

// File: rtl/perm_result_reg.sv
// Module: perm_result_reg
// Holds the permuted vector and its valid flag; loads only on a valid request.
// Assumes a synchronous active-low reset that clears both data and flag.
module perm_result_reg #(
    parameter int WIDTH = perm_pkg::DEF_LANES * perm_pkg::DEF_BYTE_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic [WIDTH-1:0]  d,
    output logic [WIDTH-1:0]  q,
    output logic              q_valid
);
    // Capture new data on a request, otherwise keep the last result.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q       <= '0;
            q_valid <= 1'b0;
        end else begin
            q_valid <= load;
            if (load) begin
                q <= d;
            end
        end
    end
endmodule

// File: rtl/byte_permute_unit.sv
// Module: byte_permute_unit
// Full 2*LANES-to-LANES byte crossbar with one registered stage.
// Each output lane reads its control byte and uses the low IDX_W bits as a
// pool index. Lower indices address src_a and upper ones src_b. Control bits
// above the index are discarded. Assumes BYTE_W > IDX_W.
module byte_permute_unit #(
    parameter int LANES  = perm_pkg::DEF_LANES,
    parameter int BYTE_W = perm_pkg::DEF_BYTE_W
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      in_valid,
    input  logic [LANES*BYTE_W-1:0]   src_a,
    input  logic [LANES*BYTE_W-1:0]   src_b,
    input  logic [LANES*BYTE_W-1:0]   ctrl,
    output logic                      out_valid,
    output logic [LANES*BYTE_W-1:0]   result
);
    localparam int VEC_W  = LANES * BYTE_W;
    localparam int IDX_W  = $clog2(LANES) + 1;
    localparam int SPARE_W = BYTE_W - IDX_W;

    logic [LANES-1:0][BYTE_W-1:0]  lanes_a;
    logic [LANES-1:0][BYTE_W-1:0]  lanes_b;
    logic [LANES-1:0][BYTE_W-1:0]  lanes_c;
    logic [LANES-1:0][BYTE_W-1:0]  lanes_r;
    logic [LANES*SPARE_W-1:0]      unused_ctl_hi;
    logic [VEC_W-1:0]              permuted;

    perm_unpack #(.LANES(LANES), .BYTE_W(BYTE_W)) u_unpack_a (
        .vec(src_a), .lanes(lanes_a));
    perm_unpack #(.LANES(LANES), .BYTE_W(BYTE_W)) u_unpack_b (
        .vec(src_b), .lanes(lanes_b));
    perm_unpack #(.LANES(LANES), .BYTE_W(BYTE_W)) u_unpack_c (
        .vec(ctrl), .lanes(lanes_c));

    for (genvar k = 0; k < LANES; k++) begin : g_lane
        // Collect the discarded control bits of lane k.
        assign unused_ctl_hi[k*SPARE_W +: SPARE_W] = lanes_c[k][BYTE_W-1:IDX_W];

        perm_lane_select #(.LANES(LANES), .BYTE_W(BYTE_W)) u_sel (
            .pool_a (lanes_a),
            .pool_b (lanes_b),
            .index  (lanes_c[k][IDX_W-1:0]),
            .pick   (lanes_r[k])
        );
    end

    perm_pack #(.LANES(LANES), .BYTE_W(BYTE_W)) u_pack (
        .lanes(lanes_r), .vec(permuted));

    perm_result_reg #(.WIDTH(VEC_W)) u_out (
        .clk     (clk),
        .rst_n   (rst_n),
        .load    (in_valid),
        .d       (permuted),
        .q       (result),
        .q_valid (out_valid)
    );
endmodule

// File: rtl/byte_permute_unit_chk.sv
// Module: byte_permute_unit_chk
// Property checker for byte_permute_unit, attached by bind below.
// Assumes inputs settle before each rising edge.
module byte_permute_unit_chk #(
    parameter int LANES  = perm_pkg::DEF_LANES,
    parameter int BYTE_W = perm_pkg::DEF_BYTE_W
) (
    input logic                     clk,
    input logic                     rst_n,
    input logic                     in_valid,
    input logic [LANES*BYTE_W-1:0]  src_a,
    input logic [LANES*BYTE_W-1:0]  src_b,
    input logic [LANES*BYTE_W-1:0]  ctrl,
    input logic                     out_valid,
    input logic [LANES*BYTE_W-1:0]  result
);
    localparam int VEC_W = LANES * BYTE_W;
    localparam int IMASK = 2 * LANES - 1;

    // Behavioural model of the lane selection (R1, R2).
    function automatic logic [VEC_W-1:0] model(
        input logic [VEC_W-1:0] a, input logic [VEC_W-1:0] b,
        input logic [VEC_W-1:0] c);
        logic [VEC_W-1:0] r;
        r = '0;
        for (int k = 0; k < LANES; k++) begin
            int p;
            p = int'(c[VEC_W-1-k*BYTE_W -: BYTE_W]) & IMASK;
            if (p < LANES)
                r[VEC_W-1-k*BYTE_W -: BYTE_W] = a[VEC_W-1-p*BYTE_W -: BYTE_W];
            else
                r[VEC_W-1-k*BYTE_W -: BYTE_W] = b[VEC_W-1-(p-LANES)*BYTE_W -: BYTE_W];
        end
        return r;
    endfunction

    // R1/R2/R7: a valid request yields the modelled permutation next cycle.
    a_r1_lane_pick: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> (result == model($past(src_a), $past(src_b), $past(ctrl))));

    // R3/R4: each valid request raises out_valid one cycle later.
    a_r3_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid);

    // R5: no request means no valid flag on the next cycle.
    a_r5_no_spurious: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> !out_valid);

    // R5: no request means the result is held.
    a_r5_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> $stable(result));

    // R6: reset clears flag and data.
    a_r6_reset_clear: assert property (@(posedge clk)
        !rst_n |=> (!out_valid && result == '0));
endmodule

bind byte_permute_unit byte_permute_unit_chk #(.LANES(LANES), .BYTE_W(BYTE_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .src_a(src_a),
    .src_b(src_b), .ctrl(ctrl), .out_valid(out_valid), .result(result));

// File: tb/byte_permute_unit_test.sv
// Bench for byte_permute_unit: a vector table walked by one loop, then
// directed tests for reset, hold, streaming and table lookup.
module byte_permute_unit_test;
    localparam int NV = 7;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         in_valid = 1'b0;
    logic [127:0] src_a = '0, src_b = '0, ctrl = '0;
    logic         out_valid;
    logic [127:0] result;

    int  checks = 0;
    int  fails = 0;
    bit  done = 1'b0;

    always #10 clk = ~clk;  // 50 MHz

    byte_permute_unit uut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .src_a(src_a),
        .src_b(src_b), .ctrl(ctrl), .out_valid(out_valid), .result(result));

    localparam logic [127:0] TA = 128'h00112233445566778899AABBCCDDEEFF;
    localparam logic [127:0] TB = 128'h0123456789ABCDEFFEDCBA9876543210;

    localparam logic [127:0] TV_CTL [NV] = '{
        128'h000102030405060708090A0B0C0D0E0F,
        128'h101112131415161718191A1B1C1D1E1F,
        128'h0F0E0D0C0B0A09080706050403020100,
        {16{8'h05}},
        128'hE0E1E2E3E4E5E6E7E8E9EAEBECEDEEEF,
        128'h00100111021203130414051506160717,
        {16{8'hBF}}
    };
    localparam logic [127:0] TV_EXP [NV] = '{
        TA,
        TB,
        128'hFFEEDDCCBBAA99887766554433221100,
        {16{8'h55}},
        TA,
        128'h0001112322453367448955AB66CD77EF,
        {16{8'h10}}
    };
    localparam string TV_REQ [NV] = '{"R1", "R1", "R1", "R7", "R2", "R1", "R2"};

    // Expected result from the lane-selection rule of R1 and R2.
    function automatic logic [127:0] expect_perm(input logic [127:0] a,
        input logic [127:0] b, input logic [127:0] c);
        logic [127:0] r;
        for (int k = 0; k < 16; k++) begin
            int p;
            p = int'(c[127-8*k -: 8]) & 31;
            r[127-8*k -: 8] = (p < 16) ? a[127-8*p -: 8] : b[127-8*(p-16) -: 8];
        end
        return r;
    endfunction

    task automatic check(input string req, input logic [127:0] act, input logic [127:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: got %h expected %h", req, act, exp);
        end
    endtask

    task automatic drive(input logic v, input logic [127:0] a,
        input logic [127:0] b, input logic [127:0] c);
        in_valid = v; src_a = a; src_b = b; ctrl = c;
    endtask

    function automatic logic [127:0] rnd128();
        return {$urandom, $urandom, $urandom, $urandom};
    endfunction

    initial begin
        logic [127:0] held;
        logic [127:0] sa [8], sb [8], sc [8];
        logic [127:0] tbl_a, tbl_b, idx;

        // R6: reset state
        repeat (2) @(negedge clk);
        check("R6 valid", {127'd0, out_valid}, '0);
        check("R6 data", result, '0);
        rst_n = 1'b1;

        // Table walk: R1, R2, R7
        for (int i = 0; i < NV; i++) begin
            @(negedge clk);
            drive(1'b1, TA, TB, TV_CTL[i]);
            @(negedge clk);
            drive(1'b0, '0, '0, '0);
            check(TV_REQ[i], result, TV_EXP[i]);
            check("R3 valid", {127'd0, out_valid}, 128'd1);
        end

        // R5: idle with changing operands keeps result, flag low
        held = result;
        for (int i = 0; i < 3; i++) begin
            @(negedge clk);
            drive(1'b0, rnd128(), rnd128(), rnd128());
            @(negedge clk);
            check("R5 hold", result, held);
            check("R5 valid", {127'd0, out_valid}, '0);
        end

        // R4: back-to-back stream of 8 requests
        for (int i = 0; i < 8; i++) begin
            sa[i] = rnd128(); sb[i] = rnd128(); sc[i] = rnd128();
        end
        for (int i = 0; i <= 8; i++) begin
            @(negedge clk);
            if (i > 0) begin
                check("R4 stream", result, expect_perm(sa[i-1], sb[i-1], sc[i-1]));
                check("R4 valid", {127'd0, out_valid}, 128'd1);
            end
            if (i < 8) drive(1'b1, sa[i], sb[i], sc[i]);
            else drive(1'b0, '0, '0, '0);
        end
        @(negedge clk);
        check("R3 flag drop", {127'd0, out_valid}, '0);

        // R8: 32-entry table lookup, entry n = n*7+3
        for (int n = 0; n < 16; n++) begin
            tbl_a[127-8*n -: 8] = 8'(n * 7 + 3);
            tbl_b[127-8*n -: 8] = 8'((n + 16) * 7 + 3);
        end
        for (int t = 0; t < 4; t++) begin
            logic [127:0] want;
            idx = rnd128();
            for (int k = 0; k < 16; k++)
                want[127-8*k -: 8] = 8'((int'(idx[127-8*k -: 8]) & 31) * 7 + 3);
            @(negedge clk);
            drive(1'b1, tbl_a, tbl_b, idx);
            @(negedge clk);
            drive(1'b0, '0, '0, '0);
            check("R8 lookup", result, want);
        end

        // R6: reset in mid-run clears a nonzero result
        @(negedge clk);
        drive(1'b1, TA, TB, TV_CTL[0]);
        rst_n = 1'b0;
        @(negedge clk);
        drive(1'b0, '0, '0, '0);
        check("R6 mid reset data", result, '0);
        check("R6 mid reset valid", {127'd0, out_valid}, '0);
        rst_n = 1'b1;

        done = 1'b1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    // Watchdog: a hung run counts as a failed check.
    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end
endmodule